// File: doc/BRIEF.md
# Dual-Bank L2 Address Hash Unit

This block turns a forwarding-table lookup key into bucket indices for a four-way set-associative L2 address table. The 60-bit key is a 12-bit VLAN ID above a 48-bit MAC address. Two XOR-fold hash functions are computed side by side. The first folds the key's chunks directly. The second rotates two of those chunks before it folds them. A two-bit algorithm select picks one of the two results for each of the two table banks.

Bank 0 uses the lower half of the 4096-bucket space and bank 1 the upper half. Both indices are returned on their own and packed into one 32-bit word. Each is also expanded into a full table row address by appending a way number. The result can be taken combinationally, or through one output register stage that carries a valid flag.

Top module: `l2hash_unit`

## Requirements
- R1: Algorithm 0 is the XOR of key bits 59:55 (zero-extended to 11 bits) with the five 11-bit slices 54:44, 43:33, 32:22, 21:11 and 10:0.
- R2: Algorithm 1 is the same fold, but slice s=key[21:11] enters as {s[4:0], s[10:5]} and slice t=key[43:33] enters as {t[5:0], t[10:6]}.
- R3: alg_sel[0]=1 makes bank 0 use algorithm 1, and alg_sel[0]=0 makes it use algorithm 0.
- R4: alg_sel[1] makes the same choice for bank 1, independently of alg_sel[0].
- R5: bank0_idx is {1'b0, hash}, so it is always below 2048. bank1_idx is hash + 2048, i.e. {1'b1, hash}.
- R6: Each row address is {bucket index, way_sel[1:0]}, with the way in the two least significant bits.
- R7: idx_pair carries bank0_idx in bits 15:0 and bank1_idx in bits 31:16, with the unused upper four bits of each half at zero.
- R8: With the register stage enabled, results for a key appear on the first rising edge after in_valid is seen high, and out_valid is high in that same cycle.
- R9: A cycle with in_valid low clears out_valid and leaves every index and row output unchanged.
- R10: After reset, out_valid is 0 and every index, row and packed output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output stage |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Key, select and way are valid this cycle |
| key | input | 60 | {VLAN ID[11:0], MAC[47:0]} |
| alg_sel | input | 2 | Bit 0 is the algorithm for bank 0, bit 1 is the algorithm for bank 1 (1 = rotated fold) |
| way_sel | input | 2 | Way number placed in the row addresses |
| out_valid | output | 1 | Results below are new this cycle |
| bank0_idx | output | 12 | Bank-0 bucket index (0..2047) |
| bank1_idx | output | 12 | Bank-1 bucket index (2048..4095) |
| idx_pair | output | 32 | {4'b0, bank1_idx, 4'b0, bank0_idx} |
| bank0_row | output | 14 | {bank0_idx, way_sel} |
| bank1_row | output | 14 | {bank1_idx, way_sel} |

## Verification
The two banks select their algorithms in the same cycle, from the same key, through separate select bits. Mixed settings (01 and 10) are therefore driven on keys where the two algorithms disagree, and the bench confirms that each bank follows only its own bit. The way is inserted into both row addresses in that same cycle. Every row is judged against a bench model that builds the bucket first and then appends the way.

// File: rtl/l2h_pkg.sv
package l2h_pkg;
    localparam int KEY_W    = 60;
    localparam int HASH_W   = 11;
    localparam int WAY_W    = 2;
    localparam int NSLICE   = KEY_W / HASH_W;
    localparam int TOP_W    = KEY_W - NSLICE * HASH_W;
    localparam int IDX_W    = HASH_W + 1;
    localparam int ROW_W    = IDX_W + WAY_W;
    localparam int HALF_W   = 16;
    localparam int ROT_A_SL = 1;
    localparam int ROT_A    = 5;
    localparam int ROT_B_SL = 3;
    localparam int ROT_B    = 6;

    typedef logic [KEY_W-1:0]  key_t;
    typedef logic [HASH_W-1:0] hash_t;
    typedef logic [IDX_W-1:0]  idx_t;
    typedef logic [ROW_W-1:0]  row_t;
    typedef logic [WAY_W-1:0]  way_t;

    typedef struct packed {
        logic valid;
        idx_t idx0;
        idx_t idx1;
        row_t row0;
        row_t row1;
    } res_t;

    function automatic hash_t rotr(input hash_t v, input int n);
        hash_t r;
        r = v;
        for (int i = 0; i < n; i++) r = {r[0], r[HASH_W-1:1]};
        return r;
    endfunction
endpackage

// File: rtl/l2h_fold.sv
module l2h_fold
    import l2h_pkg::*;
#(
    parameter bit ROTATE = 1'b0
) (
    input  key_t  key,
    output hash_t hash
);
    hash_t acc;
    always_comb begin
        acc = hash_t'(key[KEY_W-1 -: TOP_W]);
        for (int i = 0; i < NSLICE; i++) begin
            hash_t s;
            s = key[i*HASH_W +: HASH_W];
            if (ROTATE && i == ROT_A_SL) s = rotr(s, ROT_A);
            if (ROTATE && i == ROT_B_SL) s = rotr(s, ROT_B);
            acc = acc ^ s;
        end
    end
    assign hash = acc;
endmodule

// File: rtl/l2h_bank.sv
module l2h_bank
    import l2h_pkg::*;
#(
    parameter bit UPPER = 1'b0
) (
    input  hash_t h_plain,
    input  hash_t h_rot,
    input  logic  use_rot,
    input  way_t  way,
    output idx_t  idx,
    output row_t  row
);
    hash_t pick;
    always_comb begin
        pick = use_rot ? h_rot : h_plain;
        idx  = {UPPER, pick};
        row  = {idx, way};
    end
endmodule

// File: rtl/l2hash_unit.sv
module l2hash_unit
    import l2h_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic [59:0] key,
    input  logic [1:0]  alg_sel,
    input  logic [1:0]  way_sel,
    output logic        out_valid,
    output logic [11:0] bank0_idx,
    output logic [11:0] bank1_idx,
    output logic [31:0] idx_pair,
    output logic [13:0] bank0_row,
    output logic [13:0] bank1_row
);
    hash_t h_plain, h_rot;
    idx_t  idx0_c, idx1_c;
    row_t  row0_c, row1_c;
    res_t  res_d, res_q, res_o;

    l2h_fold #(.ROTATE(1'b0)) u_fold_plain (.key(key), .hash(h_plain));
    l2h_fold #(.ROTATE(1'b1)) u_fold_rot   (.key(key), .hash(h_rot));

    l2h_bank #(.UPPER(1'b0)) u_bank0 (
        .h_plain(h_plain), .h_rot(h_rot), .use_rot(alg_sel[0]),
        .way(way_sel), .idx(idx0_c), .row(row0_c));
    l2h_bank #(.UPPER(1'b1)) u_bank1 (
        .h_plain(h_plain), .h_rot(h_rot), .use_rot(alg_sel[1]),
        .way(way_sel), .idx(idx1_c), .row(row1_c));

    always_comb begin
        res_d       = res_q;
        res_d.valid = in_valid;
        if (in_valid) begin
            res_d.idx0 = idx0_c;
            res_d.idx1 = idx1_c;
            res_d.row0 = row0_c;
            res_d.row1 = row1_c;
        end
    end

    generate
        if (REG_OUT) begin : g_reg
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) res_q <= '0;
                else        res_q <= res_d;
            end
            assign res_o = res_q;

            assert_valid_lat_R8: assert property (@(posedge clk) disable iff (!rst_n)
                out_valid == $past(in_valid));
            assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
                !$past(in_valid) |-> ($stable(bank0_idx) && $stable(bank1_idx)
                                      && $stable(bank0_row) && $stable(bank1_row)));
            assert_bank_half_R5: assert property (@(posedge clk) disable iff (!rst_n)
                out_valid |-> (!bank0_idx[11] && bank1_idx[11]));
            assert_way_rows_R6: assert property (@(posedge clk) disable iff (!rst_n)
                out_valid |-> (bank0_row[1:0] == $past(way_sel)
                               && bank1_row[1:0] == $past(way_sel)));
            assert_same_alg_R4: assert property (@(posedge clk) disable iff (!rst_n)
                ($past(in_valid) && $past(alg_sel[0]) == $past(alg_sel[1]))
                |-> (bank0_idx[10:0] == bank1_idx[10:0]));
            assert_pair_R7: assert property (@(posedge clk) disable iff (!rst_n)
                (idx_pair[31:28] == 4'd0 && idx_pair[15:12] == 4'd0
                 && idx_pair[27:16] == bank1_row[13:2]));
        end else begin : g_comb
            always_comb begin
                res_q = '0;
            end
            always_comb begin
                res_o       = res_d;
                res_o.idx0  = idx0_c;
                res_o.idx1  = idx1_c;
                res_o.row0  = row0_c;
                res_o.row1  = row1_c;
            end
        end
    endgenerate

    assign out_valid = res_o.valid;
    assign bank0_idx = res_o.idx0;
    assign bank1_idx = res_o.idx1;
    assign bank0_row = res_o.row0;
    assign bank1_row = res_o.row1;
    assign idx_pair  = {(HALF_W-IDX_W)'(0), res_o.idx1, (HALF_W-IDX_W)'(0), res_o.idx0};
endmodule

// File: tb/l2hash_unit_test.sv
module l2hash_unit_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [59:0] key = '0;
    logic [1:0]  alg_sel = '0;
    logic [1:0]  way_sel = '0;
    logic        out_valid;
    logic [11:0] bank0_idx, bank1_idx;
    logic [31:0] idx_pair;
    logic [13:0] bank0_row, bank1_row;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    l2hash_unit uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .key(key),
        .alg_sel(alg_sel), .way_sel(way_sel), .out_valid(out_valid),
        .bank0_idx(bank0_idx), .bank1_idx(bank1_idx), .idx_pair(idx_pair),
        .bank0_row(bank0_row), .bank1_row(bank1_row));

    // Reference fold written with 64-bit shifts and masks.
    function automatic logic [31:0] ref_hash(input logic [59:0] k, input bit rot);
        logic [63:0] s;
        logic [31:0] a, b, h;
        s = {4'b0, k};
        a = 32'((s >> 11) & 64'h7ff);
        b = 32'((s >> 33) & 64'h7ff);
        if (rot) begin
            a = ((a & 32'h1f) << 6) | ((a >> 5) & 32'h3f);
            b = ((b & 32'h3f) << 5) | ((b >> 6) & 32'h1f);
        end
        h = 32'((s >> 55) & 64'h1f) ^ 32'((s >> 44) & 64'h7ff) ^ b
          ^ 32'((s >> 22) & 64'h7ff) ^ a ^ 32'(s & 64'h7ff);
        return h;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive one keyed cycle, then check the registered result.
    task automatic run(input logic [59:0] k, input logic [1:0] sel, input logic [1:0] w,
                       input string tag);
        logic [31:0] e0, e1;
        @(negedge clk);
        in_valid = 1'b1; key = k; alg_sel = sel; way_sel = w;
        e0 = ref_hash(k, sel[0]);
        e1 = ref_hash(k, sel[1]) + 32'd2048;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        chk({tag, " R8 valid"}, 32'(out_valid), 32'd1);
        chk({tag, " R3 bank0"}, 32'(bank0_idx), e0);
        chk({tag, " R4 R5 bank1"}, 32'(bank1_idx), e1);
        chk({tag, " R6 row0"}, 32'(bank0_row), (e0 << 2) | 32'(w));
        chk({tag, " R6 row1"}, 32'(bank1_row), (e1 << 2) | 32'(w));
        chk({tag, " R7 pair"}, idx_pair, (e1 << 16) | e0);
    endtask

    initial begin
        repeat (2000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] seed;
        logic [59:0] rk;
        logic [11:0] h0, h1;
        seed = 32'd7;
        void'($urandom(seed));
        #(CLK_PERIOD*2);
        @(negedge clk);
        // R10: reset state
        chk("R10 valid", 32'(out_valid), 0);
        chk("R10 idx", {bank0_idx, bank1_idx, 8'd0}, 0);
        chk("R10 pair", idx_pair, 0);
        chk("R10 rows", {4'd0, bank0_row, bank1_row}, 0);
        rst_n = 1'b1;

        // R1 direct folds of single slices
        run(60'h0, 2'b00, 2'd0, "R1 zero");
        chk("R1 zero hash", 32'(bank0_idx), 0);
        run(60'h800_0000_0000_0000, 2'b00, 2'd1, "R1 top");
        chk("R1 top bit", 32'(bank0_idx), 32'h10);
        run(60'h0000_0000_0080_0000, 2'b00, 2'd2, "R1 slice");
        chk("R1 slice bit", 32'(bank0_idx), 32'h2);
        // R2 rotation of slice 21:11: bit 11 moves to bit 6; slice 43:33 bit 33 to bit 5
        run(60'h0000_0000_0000_0800, 2'b01, 2'd3, "R2 rotA");
        chk("R2 rotA bit", 32'(bank0_idx), 32'h40);
        chk("R1 plain in bank1", 32'(bank1_idx), 32'h801);
        run(60'h0000_0002_0000_0000, 2'b10, 2'd0, "R2 rotB");
        chk("R2 rotB bit", 32'(bank1_idx), 32'h820);
        chk("R1 plain in bank0", 32'(bank0_idx), 32'h1);
        // all ones and every select setting
        for (int s = 0; s < 4; s++) run({60{1'b1}}, 2'(s), 2'(s), "R5 ones");

        // R9: idle cycle with a changed key must not move outputs
        run(60'h123_4567_89ab_cdef, 2'b11, 2'd2, "R9 pre");
        h0 = bank0_idx; h1 = bank1_idx;
        @(negedge clk);
        in_valid = 1'b0; key = 60'hfed_cba9_8765_4321; alg_sel = 2'b00; way_sel = 2'd1;
        @(posedge clk);
        @(negedge clk);
        chk("R9 valid low", 32'(out_valid), 0);
        chk("R9 idx0 held", 32'(bank0_idx), 32'(h0));
        chk("R9 idx1 held", 32'(bank1_idx), 32'(h1));
        chk("R9 row held", 32'(bank0_row[1:0]), 32'd2);

        // random keys, all select mixes
        for (int i = 0; i < 300; i++) begin
            rk = {$urandom(), $urandom()} ;
            run(rk, 2'($urandom()), 2'($urandom()), "rand R1 R2");
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule